// File: doc/BRIEF.md
# Unaligned Word Read Unit

This block returns a 32-bit load result from any byte address in one memory access, whether or not the address is a multiple of four. It drives both read ports of a small dual-port word memory at once. One port fetches the word that holds the addressed byte, and the other fetches the word after it. The two words form an eight-byte little-endian window. A four-way byte-offset multiplexer then takes the four bytes that start at the requested byte. An address with any offset therefore finishes with the same latency as an aligned one, and the pipeline never has to stall.

Byte and halfword loads use the same window. They extend their result with zeros or with the sign bit, as the request asks. A request is a single-cycle valid pulse, and its response pulse comes exactly one cycle later, because the memory read is synchronous. The byte offset, size and extension flag are registered next to the memory read, so the multiplexer always works on the values that belong to the data coming back. A separate combinational flag reports an instruction-fetch address that is not word aligned. The memory model has a one-word fill port so that it can be loaded with contents.

Top module: `uwr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` is 0.
- R2: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 in the cycle after a cycle with `req_valid` low. Back-to-back requests each get their own response.
- R3: With `req_size` = 2'b10, `rsp_data` holds the bytes at addresses a, a+1, a+2 and a+3 for every byte offset 0 to 3. The byte at a sits in bits 7:0, and each following byte sits in the next higher 8 bits.
- R4: A read that runs past the top word of memory continues at word 0, so byte addresses wrap modulo the memory size.
- R5: With `req_size` = 2'b00, bits 7:0 hold the byte at a. Bits 31:8 are zero when `req_unsigned` = 1, and copies of bit 7 when `req_unsigned` = 0.
- R6: With `req_size` = 2'b01, bits 15:0 hold the bytes at a (low) and a+1 (high), at every offset including 3. Bits 31:16 are zero when `req_unsigned` = 1, and copies of bit 15 otherwise.
- R7: `req_size` = 2'b11 is treated as a full word read, the same as 2'b10, and `req_unsigned` has no effect on word reads.
- R8: `fetch_misaligned` is 1 exactly when `fetch_addr[1:0]` is nonzero, in the same cycle.
- R9: In a cycle without a response, `rsp_data` keeps the value of the last response.
- R10: A word written through the fill port is returned by a read issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write one word into the memory model |
| fill_word_addr | input | ADDR_W-2 | Word index for the fill write |
| fill_data | input | 32 | Word to write |
| req_valid | input | 1 | Read request pulse |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| req_unsigned | input | 1 | 1 selects zero extension, 0 selects sign extension |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_data | output | 32 | Extended load result |
| fetch_addr | input | ADDR_W | Instruction-fetch byte address to check |
| fetch_misaligned | output | 1 | High when the fetch address is not word aligned |

## Verification
Word, halfword and byte reads are issued at each of the four byte offsets. This separates a correct window rotation from one that is off by a byte, and it shows whether the second word is used at all. Reads at the last bytes of memory show that the second port wraps to word 0 rather than reading beyond the top. Bytes with bit 7 set are read signed and unsigned, which tells sign extension apart from zero extension. Random addresses, sizes, fills and idle gaps then mix back-to-back requests with idle cycles, testing response timing and data hold against a shadow copy of the memory.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_e;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
endpackage

// File: rtl/uwr_addr_gen.sv
module uwr_addr_gen #(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned WA_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [WA_W-1:0]   word_lo,
  output logic [WA_W-1:0]   word_hi,
  output logic [1:0]        lane
);
  // word_hi wraps to 0 at the top through width truncation
  always_comb begin
    word_lo = byte_addr[ADDR_W-1:2];
    word_hi = byte_addr[ADDR_W-1:2] + {{(WA_W-1){1'b0}}, 1'b1};
    lane    = byte_addr[1:0];
  end
endmodule

// File: rtl/uwr_dpram.sv
module uwr_dpram #(
  parameter int unsigned WA_W  = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned DEPTH = 1 << WA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [WA_W-1:0] ra_a,
  input  logic [WA_W-1:0] ra_b,
  output logic [DW-1:0]   q_a,
  output logic [DW-1:0]   q_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      q_a <= mem[ra_a];
      q_b <= mem[ra_b];
    end
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(q_a) && $stable(q_b)));
endmodule

// File: rtl/uwr_extract.sv
module uwr_extract
  import uwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WORD_W-1:0] word_lo,
  input  logic [WORD_W-1:0] word_hi,
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic              uns,
  output logic [WORD_W-1:0] data
);
  logic [2*WORD_W-1:0] win;
  logic [WORD_W-1:0]   tap [LANES];
  logic [WORD_W-1:0]   sel;
  logic                fill_b, fill_h;

  assign win = {word_hi, word_lo};

  for (genvar g = 0; g < LANES; g++) begin : g_tap
    assign tap[g] = win[g*8 +: WORD_W];
  end

  always_comb begin
    sel    = tap[lane];
    fill_b = ~uns & sel[7];
    fill_h = ~uns & sel[15];
    case (size_e'(size))
      SZ_BYTE: data = {{(WORD_W-8){fill_b}}, sel[7:0]};
      SZ_HALF: data = {{(WORD_W-16){fill_h}}, sel[15:0]};
      default: data = sel;
    endcase
  end

  // R5
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == 2'b00 && uns) |-> (data[WORD_W-1:8] == '0));
  // R6
  half_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == 2'b01 && !uns) |-> (data[WORD_W-1:16] == {(WORD_W-16){data[15]}}));
  // R3
  aligned_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && lane == 2'b00 && size[1]) |-> (data == word_lo));
endmodule

// File: rtl/uwr_unit.sv
module uwr_unit
  import uwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [WA_W-1:0]   fill_word_addr,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_misaligned
);
  logic [WA_W-1:0]   wa_lo, wa_hi;
  logic [1:0]        lane;
  logic [WORD_W-1:0] q_lo, q_hi;

  logic       valid_q, valid_d;
  logic [1:0] lane_q, lane_d;
  logic [1:0] size_q, size_d;
  logic       uns_q, uns_d;

  uwr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .byte_addr (req_addr),
    .word_lo   (wa_lo),
    .word_hi   (wa_hi),
    .lane      (lane)
  );

  uwr_dpram #(.WA_W(WA_W), .DW(WORD_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fill_en),
    .wr_addr (fill_word_addr),
    .wr_data (fill_data),
    .rd_en   (req_valid),
    .ra_a    (wa_lo),
    .ra_b    (wa_hi),
    .q_a     (q_lo),
    .q_b     (q_hi)
  );

  // request attributes travel with the synchronous read
  always_comb begin
    valid_d = req_valid;
    lane_d  = lane_q;
    size_d  = size_q;
    uns_d   = uns_q;
    if (req_valid) begin
      lane_d = lane;
      size_d = req_size;
      uns_d  = req_unsigned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lane_q  <= 2'b00;
      size_q  <= 2'b00;
      uns_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      lane_q  <= lane_d;
      size_q  <= size_d;
      uns_q   <= uns_d;
    end
  end

  uwr_extract u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid_q),
    .word_lo (q_lo),
    .word_hi (q_hi),
    .lane    (lane_q),
    .size    (size_q),
    .uns     (uns_q),
    .data    (rsp_data)
  );

  assign rsp_valid        = valid_q;
  assign fetch_misaligned = |fetch_addr[1:0];

  // R2
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/sim_uwr_unit.sv
module sim_uwr_unit;
  localparam int AW    = 10;
  localparam int WAW   = AW - 2;
  localparam int WORDS = 1 << WAW;
  localparam int BYTES = WORDS * 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            fill_en;
  logic [WAW-1:0]  fill_word_addr;
  logic [31:0]     fill_data;
  logic            req_valid;
  logic [AW-1:0]   req_addr;
  logic [1:0]      req_size;
  logic            req_unsigned;
  logic            rsp_valid;
  logic [31:0]     rsp_data;
  logic [AW-1:0]   fetch_addr;
  logic            fetch_misaligned;

  uwr_unit #(.ADDR_W(AW)) u0 (.*);

  always #2 clk = ~clk;

  logic [31:0] shadow [WORDS];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          pend = 0;
  bit          have_last = 0;
  logic [31:0] exp_q, last_rsp;
  string       tag_q;

  function automatic logic [7:0] byte_at(int a);
    int m = a % BYTES;
    return shadow[m / 4][(m % 4)*8 +: 8];
  endfunction

  function automatic logic [31:0] model(int a, logic [1:0] sz, logic u);
    logic [7:0] b0 = byte_at(a);
    logic [7:0] b1 = byte_at(a + 1);
    logic [7:0] b2 = byte_at(a + 2);
    logic [7:0] b3 = byte_at(a + 3);
    case (sz)
      2'b00:   return {{24{~u & b0[7]}}, b0};
      2'b01:   return {{16{~u & b1[7]}}, b1, b0};
      default: return {b3, b2, b1, b0};
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one cycle: check last cycle's response, then drive new inputs
  task automatic step(bit rv, int a, logic [1:0] sz, logic u, string tag,
                      bit fe, int fwa, logic [31:0] fd);
    logic [AW-1:0] fa;
    @(negedge clk);
    check(rsp_valid == pend, "R2 rsp_valid timing", 32'(rsp_valid), 32'(pend));
    if (pend) begin
      check(rsp_data == exp_q, tag_q, rsp_data, exp_q);
      last_rsp  = exp_q;
      have_last = 1;
    end else if (have_last) begin
      check(rsp_data == last_rsp, "R9 hold", rsp_data, last_rsp);
    end
    fill_en        = fe;
    fill_word_addr = WAW'(fwa);
    fill_data      = fd;
    if (fe) shadow[fwa % WORDS] = fd;
    req_valid    = rv;
    req_addr     = AW'(a);
    req_size     = sz;
    req_unsigned = u;
    pend  = rv;
    tag_q = tag;
    if (rv) exp_q = model(a, sz, u);
    fa = AW'($urandom);
    fetch_addr = fa;
    #1;
    check(fetch_misaligned == (fa[1:0] != 2'b00), "R8 fetch flag",
          32'(fetch_misaligned), 32'(fa[1:0] != 2'b00));
  endtask

  task automatic rd(int a, logic [1:0] sz, logic u, string tag);
    step(1, a, sz, u, tag, 0, 0, 32'h0);
  endtask

  task automatic fill(int w, logic [31:0] d);
    step(0, 0, 2'b10, 0, "", 1, w, d);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; fill_en = 0; fill_word_addr = '0; fill_data = '0;
    req_valid = 0; req_addr = '0; req_size = 2'b10; req_unsigned = 0;
    fetch_addr = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 reset valid", 32'(rsp_valid), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 after reset", 32'(rsp_valid), 32'h0);

    for (int w = 0; w < WORDS; w++) fill(w, $urandom);
    fill(5, 32'h80FF7F01);
    fill(6, 32'hC3A55A3C);
    fill(WORDS-1, 32'hF1E2D3C4);
    fill(0, 32'h8877B655);

    // R3 every offset, word
    for (int o = 0; o < 4; o++) rd(20 + o, 2'b10, 0, "R3 word offset");
    // R6 halfword at every offset, both extensions
    for (int o = 0; o < 4; o++) begin
      rd(20 + o, 2'b01, 0, "R6 half signed");
      rd(20 + o, 2'b01, 1, "R6 half unsigned");
    end
    // R5 bytes with bit 7 set and clear
    for (int o = 0; o < 4; o++) begin
      rd(20 + o, 2'b00, 0, "R5 byte signed");
      rd(20 + o, 2'b00, 1, "R5 byte unsigned");
    end
    // R7 alternate word code and unsigned flag on words
    rd(21, 2'b11, 0, "R7 size 11");
    rd(23, 2'b11, 1, "R7 size 11 unsigned");
    rd(22, 2'b10, 1, "R7 word unsigned");
    // R4 top-of-memory wrap
    for (int o = 1; o < 4; o++) rd(BYTES - 4 + o, 2'b10, 0, "R4 wrap word");
    rd(BYTES - 1, 2'b01, 0, "R4 wrap half");
    step(0, 0, 2'b10, 0, "", 0, 0, 32'h0);
    // R10 fill then read next cycle
    fill(10, 32'h13579BDF);
    rd(41, 2'b10, 0, "R10 fill then read");

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) fill($urandom_range(0, WORDS-1), $urandom);
      else if (r < 3) step(0, 0, 2'b10, 0, "", 0, 0, 32'h0);
      else rd($urandom_range(0, BYTES-1), 2'($urandom), 1'($urandom),
              "R3 R5 R6 random read");
    end
    step(0, 0, 2'b10, 0, "", 0, 0, 32'h0);
    step(0, 0, 2'b10, 0, "", 0, 0, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule